// File: doc/BRIEF.md
# Single-Pulse PWM Generator

This block is a PWM time base with a bank of output channels. Its main use is the one-shot mode. Software sets the enable bit, and every channel pin goes active at once while the time-base counter starts from zero. Each pin falls back to inactive when the counter reaches that channel's duty value. When the counter reaches the period value, the block returns to idle on its own: the counter clears, all pins go inactive, the enable bit drops and a one-cycle interrupt fires. Software reads the enable status to see that the run has ended, and can set the enable again to fire another pulse.

The other time-base mode values run a plain continuous up-counting time base that shares the same counter. It wraps at the period value and re-arms the pins on every wrap. It keeps going until software clears the enable bit. The pin polarity is set by a parameter.

Top module: `spulse_pwm`

## Requirements
- R1: After reset the enable status is 0, the counter is 0, the interrupt is 0 and every pin is at its inactive level.
- R2: With the enable clear, a cycle with `en_set` high (and `en_clr` low) makes the next cycle show enable status 1, counter 0, and each channel with a non-zero duty at its active level.
- R3: While enabled, the counter increases by one per cycle. A channel's pin is active exactly while the counter is below that channel's duty value, so a duty of D below the period gives an active width of D cycles.
- R4: In the cycle after the counter equals `period` in single-pulse mode (`tb_mode` = 2'b10), the counter reads 0 and all pins are inactive.
- R5: That same cycle shows the enable status cleared and `irq` high. `irq` is high for exactly one cycle per run.
- R6: A channel whose duty is 0 never goes active.
- R7: A channel whose duty exceeds the period stays active from the start of the run through the cycle in which the counter equals the period, which is period+1 cycles.
- R8: While the enable status is 0, the counter stays at 0.
- R9: Setting the enable again after a run has ended starts a new run from count 0 with the same pin widths.
- R10: `en_set` while the enable status is already 1 has no effect. The run length and the pin widths are unchanged.
- R11: With `tb_mode` = 2'b00, the counter wraps from `period` to 0, the enable status stays 1 and `irq` stays 0.
- R12: `en_clr` while enabled makes the next cycle show enable status 0, counter 0 and all pins inactive. `en_clr` takes priority over `en_set`.
- R13: With `ACTIVE_LOW` = 0, the active pin level is 1. Setting `ACTIVE_LOW` = 1 inverts every pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_mode | input | 2 | Time-base mode; 2'b10 selects single pulse |
| en_set | input | 1 | Request to set the enable bit |
| en_clr | input | 1 | Request to clear the enable bit |
| period | input | CNT_W | Period match value |
| duty | input | NUM_CH*CNT_W | Duty values, channel i in bits [i*CNT_W +: CNT_W] |
| pwm_pin | output | NUM_CH | Channel output pins |
| en_stat | output | 1 | Enable bit readback |
| irq | output | 1 | One-cycle end-of-run interrupt |
| count | output | CNT_W | Time-base counter value |

## Verification
The assertions assume that `tb_mode`, `period` and `duty` do not change while the enable status is 1. The counter-step and idle-on-interrupt checks rely on that. The random stimulus changes these inputs only in cycles where the bench's own model shows the block idle. While a run is in progress, it fires only `en_set` and `en_clr` pulses. Directed runs cover a zero duty, a duty equal to the period, a duty beyond the period, a set request during a run, and a wrap in continuous mode.

// File: rtl/spw_pkg.sv
package spw_pkg;
    typedef enum logic [1:0] {
        TB_FREE   = 2'b00,
        TB_RSV1   = 2'b01,
        TB_SINGLE = 2'b10,
        TB_RSV3   = 2'b11
    } tb_mode_e;
endpackage

// File: rtl/spw_timebase.sv
module spw_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             set_req,
    input  logic             clr_req,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] cnt_nx,
    output logic             en_nx,
    output logic [CNT_W-1:0] cnt_o,
    output logic             en_o,
    output logic             irq_o
);
    import spw_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             irq;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      one_shot;

    assign one_shot = (mode == TB_SINGLE);

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!st_q.en) begin
            st_d.cnt = '0;
            st_d.en  = set_req && !clr_req;
        end else if (clr_req) begin
            st_d.cnt = '0;
            st_d.en  = 1'b0;
        end else if (st_q.cnt == per) begin
            st_d.cnt = '0;
            if (one_shot) begin
                st_d.en  = 1'b0;
                st_d.irq = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_nx = st_d.cnt;
    assign en_nx  = st_d.en;
    assign cnt_o  = st_q.cnt;
    assign en_o   = st_q.en;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/spw_chan.sv
module spw_chan #(
    parameter int CNT_W      = 16,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_nx,
    input  logic             en_nx,
    input  logic [CNT_W-1:0] duty,
    output logic             pin
);
    typedef struct packed {
        logic act;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d.act = en_nx && (cnt_nx < duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin = st_q.act ^ ACTIVE_LOW;
endmodule

// File: rtl/spulse_pwm.sv
module spulse_pwm #(
    parameter int CNT_W      = 16,
    parameter int NUM_CH     = 4,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              tb_mode,
    input  logic                    en_set,
    input  logic                    en_clr,
    input  logic [CNT_W-1:0]        period,
    input  logic [NUM_CH*CNT_W-1:0] duty,
    output logic [NUM_CH-1:0]       pwm_pin,
    output logic                    en_stat,
    output logic                    irq,
    output logic [CNT_W-1:0]        count
);
    logic [CNT_W-1:0] cnt_nx;
    logic             en_nx;

    spw_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (tb_mode),
        .set_req (en_set),
        .clr_req (en_clr),
        .per     (period),
        .cnt_nx  (cnt_nx),
        .en_nx   (en_nx),
        .cnt_o   (count),
        .en_o    (en_stat),
        .irq_o   (irq)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        spw_chan #(.CNT_W(CNT_W), .ACTIVE_LOW(ACTIVE_LOW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_nx (cnt_nx),
            .en_nx  (en_nx),
            .duty   (duty[g*CNT_W +: CNT_W]),
            .pin    (pwm_pin[g])
        );
    end
endmodule

// File: rtl/spw_chk.sv
module spw_chk #(
    parameter int CNT_W      = 16,
    parameter int NUM_CH     = 4,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        tb_mode,
    input logic              en_clr,
    input logic [CNT_W-1:0]  period,
    input logic [NUM_CH-1:0] pwm_pin,
    input logic              en_stat,
    input logic              irq,
    input logic [CNT_W-1:0]  count
);
    localparam logic [NUM_CH-1:0] IDLE_LVL = {NUM_CH{ACTIVE_LOW}};

    // R5
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5
    irq_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !en_stat);

    // R4
    irq_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pwm_pin == IDLE_LVL && count == '0));

    // R8
    idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_stat |-> count == '0);

    // R2
    start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_stat) |-> count == '0);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_stat && !en_clr && count != period) |=> (en_stat && count == CNT_W'($past(count) + 1'b1)));

    // R11
    free_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_stat && tb_mode == 2'b00) |=> !irq);
endmodule

bind spulse_pwm spw_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tb_mode (tb_mode),
    .en_clr  (en_clr),
    .period  (period),
    .pwm_pin (pwm_pin),
    .en_stat (en_stat),
    .irq     (irq),
    .count   (count)
);

// File: tb/spulse_pwm_tb.sv
`timescale 1ns/1ps
module spulse_pwm_tb;
    localparam int CW = 16;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    tb_mode = 2'b10;
    logic          en_set = 1'b0;
    logic          en_clr = 1'b0;
    logic [CW-1:0] period = '0;
    logic [NC*CW-1:0] duty = '0;
    logic [NC-1:0] pwm_pin;
    logic          en_stat;
    logic          irq;
    logic [CW-1:0] count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_cnt = 0;
    bit m_en  = 0;
    bit m_irq = 0;

    always #2 clk = ~clk;

    spulse_pwm #(.CNT_W(CW), .NUM_CH(NC), .ACTIVE_LOW(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .tb_mode(tb_mode), .en_set(en_set), .en_clr(en_clr),
        .period(period), .duty(duty), .pwm_pin(pwm_pin), .en_stat(en_stat),
        .irq(irq), .count(count)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int duty_of(input int ch);
        return int'(duty[ch*CW +: CW]);
    endfunction

    function automatic bit exp_pin(input int ch);
        return m_en && (m_cnt < duty_of(ch));
    endfunction

    function automatic string pin_req(input int ch);
        if (duty_of(ch) == 0) return "R6";
        if (duty_of(ch) > int'(period)) return "R7";
        return "R3";
    endfunction

    task automatic model_edge(input bit s, input bit c);
        m_irq = 0;
        if (!m_en) begin
            m_cnt = 0;
            m_en  = s && !c;
        end else if (c) begin
            m_en = 0; m_cnt = 0;
        end else if (m_cnt == int'(period)) begin
            m_cnt = 0;
            if (tb_mode == 2'b10) begin m_en = 0; m_irq = 1; end
        end else m_cnt++;
    endtask

    task automatic compare_all();
        chk(en_stat == m_en, "R5", "en_stat", en_stat, m_en);
        chk(irq == m_irq, "R5", "irq", irq, m_irq);
        chk(int'(count) == m_cnt, m_en ? "R3" : "R8", "count", count, m_cnt);
        for (int i = 0; i < NC; i++)
            chk(pwm_pin[i] == exp_pin(i), pin_req(i), $sformatf("pin%0d", i), pwm_pin[i], exp_pin(i));
    endtask

    task automatic step(input bit s, input bit c);
        en_set = s; en_clr = c;
        @(posedge clk);
        model_edge(s, c);
        @(negedge clk);
        en_set = 0; en_clr = 0;
        compare_all();
    endtask

    task automatic run_pulse(input bit poke, output int w[NC], output int en_len, output int irq_n);
        for (int i = 0; i < NC; i++) w[i] = 0;
        en_len = 0; irq_n = 0;
        step(1, 0);
        for (int k = 0; k < 200; k++) begin
            for (int i = 0; i < NC; i++) if (pwm_pin[i]) w[i]++;
            if (en_stat) en_len++;
            if (irq) irq_n++;
            if (!en_stat && !irq) break;
            step(poke && k == 3, 0);
        end
    endtask

    initial begin
        int w[NC];
        int el, ic;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(en_stat == 0 && irq == 0, "R1", "en/irq", {en_stat, irq}, 0);
        chk(count == 0, "R1", "count", count, 0);
        chk(pwm_pin == '0, "R13", "idle pins", pwm_pin, 0);

        // directed single pulse: period 10, duties 0,3,10,15
        tb_mode = 2'b10; period = 10;
        duty = {16'd15, 16'd10, 16'd3, 16'd0};
        step(1, 0);
        chk(pwm_pin == 4'b1110, "R2", "pins at start", pwm_pin, 4'b1110);
        chk(count == 0 && en_stat, "R2", "count at start", count, 0);
        repeat (20) step(0, 0);
        run_pulse(0, w, el, ic);
        chk(w[0] == 0, "R6", "width ch0", w[0], 0);
        chk(w[1] == 3, "R3", "width ch1", w[1], 3);
        chk(w[2] == 10, "R3", "width ch2", w[2], 10);
        chk(w[3] == 11, "R7", "width ch3", w[3], 11);
        chk(el == 11, "R4", "enable length", el, 11);
        chk(ic == 1, "R5", "irq pulses", ic, 1);
        // R9 restart
        run_pulse(0, w, el, ic);
        chk(w[1] == 3 && el == 11, "R9", "restart width", w[1], 3);
        // R10 set while running
        run_pulse(1, w, el, ic);
        chk(el == 11, "R10", "enable length with set", el, 11);
        chk(w[3] == 11, "R10", "width ch3 with set", w[3], 11);

        // R11 free-running wrap
        tb_mode = 2'b00; period = 4;
        duty = {16'd5, 16'd2, 16'd1, 16'd0};
        step(1, 0);
        ic = 0;
        for (int k = 1; k <= 12; k++) begin
            step(0, 0);
            if (irq) ic++;
            chk(int'(count) == k % 5 && en_stat, "R11", "wrap count", count, k % 5);
        end
        chk(ic == 0, "R11", "irq count", ic, 0);
        // R12 clear wins over set
        step(1, 1);
        chk(!en_stat && count == 0 && pwm_pin == 0, "R12", "after clear", {en_stat, pwm_pin}, 0);
        step(1, 1);
        chk(!en_stat, "R12", "clear priority", en_stat, 0);

        // random phase
        void'($urandom(32'd1234));
        for (int k = 0; k < 3000; k++) begin
            if (!m_en && ($urandom % 4) == 0) begin
                tb_mode = (($urandom % 4) == 0) ? 2'b00 : 2'b10;
                period  = CW'($urandom % 21);
                for (int i = 0; i < NC; i++) duty[i*CW +: CW] = CW'($urandom % 26);
            end
            step(($urandom % 6) == 0, ($urandom % 40) == 0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule